// File: doc/BRIEF.md
# Peripheral Clock Prescaler with Control Byte

This block turns the system clock into a family of clock-enable strobes for the peripherals of a small microcontroller. A free-running binary counter advances on every system clock. For each power of two from 2 up to 1024 it produces a one-cycle strobe. It also produces a level enable that stands for the undivided clock. No derived clock is ever created: every consumer stays on the system clock and qualifies its logic with the strobe.

A single write-only control byte, decoded at one fixed address on a byte-wide write port, sets how the block behaves. The byte holds four controls:
- a master gate that can silence every peripheral strobe at once;
- a mode flag that tells the watchdog logic to act as a watchdog or as a plain 6-bit timer;
- a self-clearing strobe that restarts the interval timer;
- a 3-bit field that picks which prescaler tap drives the interval timer.

At reset the gate is open, so all peripherals are clocked. The interval tap select starts at its slowest setting. The asynchronous reset is released through a two-stage synchronizer.

Top module: `pclk_prescaler`

## Requirements
- R1: While reset is applied, the outputs are: `wdt_mode_o`=0, `ivl_sel_o`=3'b111, `ivl_clr_o`=0, `ivl_tick_o`=0, and `pclk_en_o`=11'b000_0000_0001.
- R2: After `rst_n` rises, the counter starts from zero on the third rising edge, because the release passes through two synchronizing stages. From then on, `pclk_en_o[k]` (k=1..10) pulses for exactly one cycle in every 2^k clocks, whenever the low k counter bits are all ones. The counter is cleared only by reset.
- R3: `pclk_en_o[0]`, the undivided tap, is high on every cycle while the gate bit is 1.
- R4: A write takes effect only when `wr_en`=1 and `wr_addr`=8'hD6. A write to any other address leaves every output unchanged.
- R5: The gate is bit 4 of the control byte. Once a write with bit 4 = 0 lands, all of `pclk_en_o` reads 0 from the very next cycle. A write with bit 4 = 1 restores the taps.
- R6: Bit 5 of the control byte drives `wdt_mode_o`. The value 1 selects watchdog operation and 0 selects the plain timer.
- R7: Writing bit 3 = 1 raises `ivl_clr_o` for exactly the one cycle after the write edge. The bit is not held, and it does not disturb the prescaler counter.
- R8: Bits 2..0 of the control byte drive `ivl_sel_o`. `ivl_tick_o` is the divide-by-2^(sel+3) strobe, which is not affected by the gate bit.
- R9: Bits 7 and 6 of the written byte have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pclk_en_o | output | 11 | Gated peripheral enables; bit 0 is undivided, bit k is the divide-by-2^k strobe |
| ivl_tick_o | output | 1 | Interval-timer tap strobe |
| ivl_sel_o | output | 3 | Interval tap select |
| ivl_clr_o | output | 1 | One-cycle interval-timer clear |
| wdt_mode_o | output | 1 | 1 = watchdog mode, 0 = plain timer |

## Verification
The bench goes after the slowest tap. Its 1024-cycle period exposes a truncated counter, or a strobe tied to the wrong counter bit, as a wrong spacing between pulses.

Gate closure is checked on the first cycle after the write. A design that registered the gate one stage late would leak one strobe.

Clear strobes are written back to back, and reserved bits and foreign addresses are written as well. A clear bit that stuck high, or a decoder that ignored the address or the reserved bits, would show up as a changed output.

A mid-run reset confirms that the counter restarts exactly two edges after release. A design that missed the synchronizer, or had one stage too many, would shift every tap by a cycle.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  // Decoded contents of the control byte
  typedef struct packed {
    logic       wdt_mode;
    logic       gate_en;
    logic       ivl_clr;
    logic [2:0] ivl_sel;
  } pclk_ctrl_t;

  localparam int unsigned BIT_WDT   = 5;
  localparam int unsigned BIT_GATE  = 4;
  localparam int unsigned BIT_CLR   = 3;
  localparam int unsigned SEL_W     = 3;
  localparam logic [2:0]  SEL_RESET = 3'b111;

  localparam pclk_ctrl_t CTRL_RESET = '{
    wdt_mode: 1'b0,
    gate_en:  1'b1,
    ivl_clr:  1'b0,
    ivl_sel:  SEL_RESET
  };

endpackage

// File: rtl/pclk_rst_sync.sv
module pclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pclk_divchain.sv
module pclk_divchain #(
  parameter int unsigned DIV_STAGES = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [DIV_STAGES:1] tap_o
);

  localparam int unsigned CNT_W = DIV_STAGES;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Divide-by-2^k strobe fires when the low k bits are all ones
  for (genvar k = 1; k <= DIV_STAGES; k++) begin : g_tap
    assign tap_o[k] = &cnt_q[k-1:0];
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pclk_ctrl_reg.sv
module pclk_ctrl_reg
  import pclk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'hD6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output pclk_ctrl_t        ctrl_o
);

  pclk_ctrl_t ctrl_q;
  pclk_ctrl_t ctrl_d;
  logic       hit;

  assign hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    ctrl_d         = ctrl_q;
    ctrl_d.ivl_clr = 1'b0;
    if (hit) begin
      ctrl_d.wdt_mode = wr_data[BIT_WDT];
      ctrl_d.gate_en  = wr_data[BIT_GATE];
      ctrl_d.ivl_clr  = wr_data[BIT_CLR];
      ctrl_d.ivl_sel  = wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable({ctrl_q.wdt_mode, ctrl_q.gate_en, ctrl_q.ivl_sel}));

  // R7
  clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.ivl_clr |-> $past(hit && wr_data[BIT_CLR]));

endmodule

// File: rtl/pclk_tap_gate.sv
module pclk_tap_gate #(
  parameter int unsigned DIV_STAGES = 10,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned SEL_BASE   = 3
) (
  input  logic [DIV_STAGES:1] tap_i,
  input  logic                gate_en,
  input  logic [SEL_W-1:0]    ivl_sel,
  output logic [DIV_STAGES:0] pclk_en_o,
  output logic                ivl_tick_o
);

  localparam int unsigned SEL_N = 1 << SEL_W;

  always_comb begin
    pclk_en_o = '0;
    if (gate_en) begin
      pclk_en_o = {tap_i, 1'b1};
    end
  end

  always_comb begin
    ivl_tick_o = 1'b0;
    for (int s = 0; s < SEL_N; s++) begin
      if ((ivl_sel == SEL_W'(s)) && (s + SEL_BASE <= DIV_STAGES)) begin
        ivl_tick_o = tap_i[s + SEL_BASE];
      end
    end
  end

endmodule

// File: rtl/pclk_prescaler.sv
module pclk_prescaler
  import pclk_pkg::*;
#(
  parameter int unsigned DIV_STAGES = 10,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  CTRL_ADDR  = 8'hD6,
  parameter int unsigned SEL_BASE   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DIV_STAGES:0] pclk_en_o,
  output logic                ivl_tick_o,
  output logic [2:0]          ivl_sel_o,
  output logic                ivl_clr_o,
  output logic                wdt_mode_o
);

  logic                rst_i_n;
  logic [DIV_STAGES:1] tap_w;
  pclk_ctrl_t          ctrl_w;

  pclk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pclk_divchain #(.DIV_STAGES(DIV_STAGES)) u_div (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tap_o (tap_w)
  );

  pclk_ctrl_reg #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_o  (ctrl_w)
  );

  pclk_tap_gate #(
    .DIV_STAGES (DIV_STAGES),
    .SEL_W      (SEL_W),
    .SEL_BASE   (SEL_BASE)
  ) u_gate (
    .tap_i      (tap_w),
    .gate_en    (ctrl_w.gate_en),
    .ivl_sel    (ctrl_w.ivl_sel),
    .pclk_en_o  (pclk_en_o),
    .ivl_tick_o (ivl_tick_o)
  );

  assign ivl_sel_o  = ctrl_w.ivl_sel;
  assign ivl_clr_o  = ctrl_w.ivl_clr;
  assign wdt_mode_o = ctrl_w.wdt_mode;

  // R5
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ctrl_w.gate_en |-> (pclk_en_o == '0));

  // R8
  ivl_tap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ivl_tick_o |-> tap_w[32'(ivl_sel_o) + SEL_BASE]);

  // R3
  undiv_tap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctrl_w.gate_en |-> pclk_en_o[0]);

endmodule

// File: tb/tb_pclk_prescaler.sv
module tb_pclk_prescaler;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [10:0] pclk_en_o;
  logic        ivl_tick_o;
  logic [2:0]  ivl_sel_o;
  logic        ivl_clr_o;
  logic        wdt_mode_o;

  always #2 clk = ~clk;

  pclk_prescaler dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pclk_en_o  (pclk_en_o),
    .ivl_tick_o (ivl_tick_o),
    .ivl_sel_o  (ivl_sel_o),
    .ivl_clr_o  (ivl_clr_o),
    .wdt_mode_o (wdt_mode_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // Reference model state
  bit m_s1, m_s2, m_pen, m_wdt, m_clr, olds;
  int m_cnt, m_sel;
  int last [11];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0;
      m_pen = 1; m_wdt = 0; m_clr = 0; m_sel = 7;
    end else begin
      olds = m_s2; m_s2 = m_s1; m_s1 = 1;
      if (!olds) begin
        m_cnt = 0; m_pen = 1; m_wdt = 0; m_clr = 0; m_sel = 7;
      end else begin
        m_cnt = (m_cnt + 1) % 1024;
        m_clr = 0;
        if (wr_en && wr_addr == 8'hD6) begin
          m_wdt = wr_data[5]; m_pen = wr_data[4];
          m_clr = wr_data[3]; m_sel = wr_data[2:0];
        end
      end
    end
  end

  // Compare against the model shortly after every rising edge
  always @(posedge clk) begin
    logic [10:0] e;
    bit tk;
    #1;
    cyc++;
    e[0] = m_pen;
    for (int k = 1; k <= 10; k++)
      e[k] = m_pen && ((m_cnt % (1 << k)) == (1 << k) - 1);
    tk = (m_cnt % (1 << (m_sel + 3))) == (1 << (m_sel + 3)) - 1;
    chk(pclk_en_o == e, m_pen ? "R2" : "R5", "pclk_en", pclk_en_o, e);
    chk(ivl_tick_o == tk, "R8", "ivl_tick", ivl_tick_o, tk);
    chk(ivl_sel_o == 3'(m_sel), "R8", "ivl_sel", ivl_sel_o, m_sel);
    chk(wdt_mode_o == m_wdt, "R6", "wdt_mode", wdt_mode_o, m_wdt);
    chk(ivl_clr_o == m_clr, "R7", "ivl_clr", ivl_clr_o, m_clr);
    for (int k = 1; k <= 10; k++) begin
      if (!m_pen || !m_s2) last[k] = -1;
      else if (pclk_en_o[k]) begin
        if (last[k] >= 0)
          chk(cyc - last[k] == (1 << k), "R2", "tap spacing", cyc - last[k], 1 << k);
        last[k] = cyc;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_addr = 8'h00; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 11; k++) last[k] = -1;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    idle(3);
    // R1 reset state
    chk(pclk_en_o == 11'h001 && ivl_tick_o == 0, "R1", "reset taps", pclk_en_o, 11'h001);
    chk(wdt_mode_o == 0 && ivl_clr_o == 0 && ivl_sel_o == 3'b111, "R1", "reset ctrl",
        {wdt_mode_o, ivl_clr_o, ivl_sel_o}, 5'b00111);
    rst_n = 1;
    idle(2100);
    // R4 foreign address
    wr(8'hD5, 8'h00);
    idle(1);
    chk(ivl_sel_o == 3'b111 && wdt_mode_o == 0 && pclk_en_o[0], "R4", "foreign write",
        {wdt_mode_o, pclk_en_o[0], ivl_sel_o}, 5'b01111);
    // R5 gate closed, R6 watchdog mode
    wr(8'hD6, 8'h27);
    chk(pclk_en_o == 0, "R5", "gate closed", pclk_en_o, 0);
    chk(wdt_mode_o == 1, "R6", "wdt mode", wdt_mode_o, 1);
    idle(40);
    // R9 reserved bits, R7 clear pulse
    wr(8'hD6, 8'hC8);
    chk(ivl_clr_o == 1, "R7", "clr pulse", ivl_clr_o, 1);
    chk(ivl_sel_o == 0 && wdt_mode_o == 0 && pclk_en_o == 0, "R9", "reserved bits",
        {wdt_mode_o, ivl_sel_o}, 0);
    idle(1);
    chk(ivl_clr_o == 0, "R7", "clr self clear", ivl_clr_o, 0);
    // R3 gate reopened
    wr(8'hD6, 8'h12);
    chk(pclk_en_o[0] == 1, "R3", "undivided tap", pclk_en_o[0], 1);
    idle(1200);
    // back-to-back clears
    @(negedge clk); wr_en = 1; wr_addr = 8'hD6; wr_data = 8'h1F;
    @(negedge clk); wr_data = 8'h1B;
    @(negedge clk); wr_en = 0;
    chk(ivl_clr_o == 1 && ivl_sel_o == 3, "R7", "second clr", {ivl_clr_o, ivl_sel_o}, 4'hB);
    idle(600);
    wr(8'hD6, 8'h17);
    idle(50);
    // mid-run reset
    rst_n = 0;
    idle(2);
    chk(pclk_en_o == 11'h001 && ivl_sel_o == 3'b111, "R1", "mid reset", pclk_en_o, 11'h001);
    rst_n = 1;
    idle(1100);
    finish_run();
  end

endmodule